// File: doc/BRIEF.md
# Bidirectional Linear Frequency Sweeper

This block generates the 32-bit tuning word that feeds a phase accumulator, and moves it linearly between a lower and an upper endpoint word. A direction input chooses between a rising slope and a falling slope. Each slope has its own control word, which packs a 32-bit step size and an 8-bit interval. While rising, the word grows by the rising step once per rising interval and stops at the upper endpoint. While falling, it shrinks by the falling step once per falling interval and stops at the lower endpoint.

An enable input starts and stops the sweep. While the sweep is disabled, the output follows the lower endpoint. The user programs the two endpoints and both control words, parks the output at the lower word with the enable low, and then raises the enable. After that, the direction pin alone steers the sweep. An external modulating signal can drive that pin to build triangle or sawtooth frequency profiles.

Top module: `freq_sweep_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, the output tuning word becomes 0 after that edge.
- R2: At any edge where sweep_en is low, the output takes the value of lo_word sampled at that edge, and no step is applied.
- R3: While rising (sweep_dir = 1) and enabled, the output increases by the rising delta (rise_ctl[39:8]) at each step edge. The step is made only if the result does not exceed hi_word.
- R4: While falling (sweep_dir = 0) and enabled, the output decreases by the falling delta (fall_ctl[39:8]) at each step edge. The step is made only if the result is not below lo_word.
- R5: Between step edges of an enabled sweep, the output keeps its value.
- R6: A rising step whose unsigned 33-bit sum is greater than hi_word, including any carry out of bit 31, sets the output to hi_word and never wraps.
- R7: A falling step whose unsigned difference is less than lo_word, including any borrow, sets the output to lo_word and never wraps.
- R8: At an enabled edge where sweep_dir differs from its value at the previous edge, no step is applied. The interval restarts with the rate of the new direction (rise_ctl[7:0] or fall_ctl[7:0]), so the next step falls R+1 edges later, where R is that rate.
- R9: The first enabled edge after a disabled edge (or after reset) applies no step. It loads the selected rate R, and the first step falls R+1 edges later. Steps then repeat every R+1 edges, so a rate of 0 steps on every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sweep_en | input | 1 | 1 runs the sweep, 0 parks the output at lo_word |
| sweep_dir | input | 1 | 1 selects the rising slope, 0 the falling slope |
| lo_word | input | 32 | Lower endpoint tuning word |
| hi_word | input | 32 | Upper endpoint tuning word |
| rise_ctl | input | 40 | Rising delta in [39:8], rising rate in [7:0] |
| fall_ctl | input | 40 | Falling delta in [39:8], falling rate in [7:0] |
| ftw_out | output | 32 | Current tuning word |

## Verification
The endpoint assertions assume that lo_word is not above hi_word and that the endpoints do not move while the sweep is enabled. Under those conditions, an unclamped rising step stays at or below the upper word, and an unclamped falling step stays at or above the lower word. The stimulus changes the endpoints and control words only while the enable is low, and always sets the lower word at or below the upper word. Within that envelope it covers carry and borrow past 32 bits, rates of 0 and larger, and rapid toggling of the direction pin. The reference model in the bench is written directly from R1 to R9, and it predicts every output value edge by edge.

// File: rtl/sweep_pkg.sv
// Package: shared sizes for the linear frequency sweeper.
// Assumes: tuning words and deltas share one width; the rate sits below the delta.
package sweep_pkg;
    localparam int unsigned TUNE_W = 32;
    localparam int unsigned RATE_W = 8;
    localparam int unsigned CTRL_W = TUNE_W + RATE_W;
    localparam int unsigned NUM_SLOPES = 2;
    // slope index used when picking a control word
    localparam int unsigned SLOPE_FALL = 0;
    localparam int unsigned SLOPE_RISE = 1;
endpackage

// File: rtl/sweep_interval_timer.sv
// Module: sweep_interval_timer
// Counts the interval between sweep steps and pulses step_fire on the edge that applies a step.
// Assumes: rate_sel is the rate of the currently selected direction; rate R gives one step per R+1 edges.
// The counter reloads when the sweep is disabled, on the first enabled edge, and on a direction change.
module sweep_interval_timer #(
    parameter int unsigned RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              run_dir,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              step_fire
);
    logic [RATE_W-1:0] tick_cnt;
    logic              en_seen;
    logic              dir_seen;
    logic              reload;

    // reload whenever the interval must restart
    always_comb begin
        reload    = !run_en || !en_seen || (run_dir != dir_seen);
        step_fire = run_en && !reload && (tick_cnt == '0);
    end

    // interval counter and history of enable and direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            en_seen  <= 1'b0;
            dir_seen <= 1'b0;
        end else begin
            en_seen  <= run_en;
            dir_seen <= run_dir;
            if (reload || (tick_cnt == '0)) begin
                tick_cnt <= rate_sel;
            end else begin
                tick_cnt <= tick_cnt - 1'b1;
            end
        end
    end

    // R9
    first_edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> !step_fire);

    // R8
    dir_flip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && $past(run_en) && (run_dir != $past(run_dir))) |-> !step_fire);
endmodule

// File: rtl/sweep_step_unit.sv
// Module: sweep_step_unit
// Holds the current tuning word and applies one clamped step per step_fire.
// Assumes: lo_bound <= hi_bound while enabled; the comparisons are unsigned with one carry bit.
module sweep_step_unit #(
    parameter int unsigned TUNE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              run_dir,
    input  logic              step_fire,
    input  logic [TUNE_W-1:0] lo_bound,
    input  logic [TUNE_W-1:0] hi_bound,
    input  logic [TUNE_W-1:0] up_delta,
    input  logic [TUNE_W-1:0] dn_delta,
    output logic [TUNE_W-1:0] tune_word
);
    logic [TUNE_W:0]   up_sum;
    logic [TUNE_W:0]   dn_diff;
    logic [TUNE_W-1:0] up_next;
    logic [TUNE_W-1:0] dn_next;

    // rising candidate, clamped at the upper bound, carry included
    always_comb begin
        up_sum = {1'b0, tune_word} + {1'b0, up_delta};
        if (up_sum[TUNE_W] || (up_sum[TUNE_W-1:0] > hi_bound)) begin
            up_next = hi_bound;
        end else begin
            up_next = up_sum[TUNE_W-1:0];
        end
    end

    // falling candidate, clamped at the lower bound, borrow included
    always_comb begin
        dn_diff = {1'b0, tune_word} - {1'b0, dn_delta};
        if (dn_diff[TUNE_W] || (dn_diff[TUNE_W-1:0] < lo_bound)) begin
            dn_next = lo_bound;
        end else begin
            dn_next = dn_diff[TUNE_W-1:0];
        end
    end

    // tuning word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tune_word <= '0;
        end else if (!run_en) begin
            tune_word <= lo_bound;
        end else if (step_fire) begin
            tune_word <= run_dir ? up_next : dn_next;
        end
    end

    // R2
    park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (tune_word == $past(lo_bound)));

    // R5
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !step_fire) |=> $stable(tune_word));

    // R6
    top_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && step_fire && run_dir && (lo_bound <= hi_bound)) |=> (tune_word <= $past(hi_bound)));

    // R7
    bottom_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && step_fire && !run_dir && (lo_bound <= hi_bound)) |=> (tune_word >= $past(lo_bound)));

    // R3
    rise_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && step_fire && run_dir && (tune_word <= hi_bound)) |=> (tune_word >= $past(tune_word)));

    // R4
    fall_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && step_fire && !run_dir && (tune_word >= lo_bound)) |=> (tune_word <= $past(tune_word)));
endmodule

// File: rtl/freq_sweep_top.sv
// Module: freq_sweep_top
// Linear frequency sweeper: splits the two slope control words, selects the active slope's rate,
// and chains the interval timer into the clamped step unit.
// Assumes: control word = {delta, rate}; endpoints are stable while the sweep is enabled.
module freq_sweep_top
    import sweep_pkg::*;
#(
    parameter int unsigned TW = TUNE_W,
    parameter int unsigned RW = RATE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sweep_en,
    input  logic             sweep_dir,
    input  logic [TW-1:0]    lo_word,
    input  logic [TW-1:0]    hi_word,
    input  logic [TW+RW-1:0] rise_ctl,
    input  logic [TW+RW-1:0] fall_ctl,
    output logic [TW-1:0]    ftw_out
);
    localparam int unsigned CW = TW + RW;

    logic [CW-1:0] slope_ctl   [NUM_SLOPES];
    logic [TW-1:0] slope_delta [NUM_SLOPES];
    logic [RW-1:0] slope_rate  [NUM_SLOPES];
    logic [RW-1:0] active_rate;
    logic          fire;

    // gather both control words by slope index
    always_comb begin
        slope_ctl[SLOPE_FALL] = fall_ctl;
        slope_ctl[SLOPE_RISE] = rise_ctl;
    end

    // split each control word into its delta and rate fields
    for (genvar s = 0; s < NUM_SLOPES; s++) begin : g_slope
        always_comb begin
            slope_delta[s] = slope_ctl[s][CW-1:RW];
            slope_rate[s]  = slope_ctl[s][RW-1:0];
        end
    end

    // rate of the direction now selected
    always_comb begin
        active_rate = sweep_dir ? slope_rate[SLOPE_RISE] : slope_rate[SLOPE_FALL];
    end

    sweep_interval_timer #(.RATE_W(RW)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (sweep_en),
        .run_dir   (sweep_dir),
        .rate_sel  (active_rate),
        .step_fire (fire)
    );

    sweep_step_unit #(.TUNE_W(TW)) step_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (sweep_en),
        .run_dir   (sweep_dir),
        .step_fire (fire),
        .lo_bound  (lo_word),
        .hi_bound  (hi_word),
        .up_delta  (slope_delta[SLOPE_RISE]),
        .dn_delta  (slope_delta[SLOPE_FALL]),
        .tune_word (ftw_out)
    );

    // R8
    flip_holds_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && $past(sweep_en) && (sweep_dir != $past(sweep_dir))) |=> $stable(ftw_out));
endmodule

// File: tb/freq_sweep_top_tb_top.sv
// Bench: scoreboard. The driver applies inputs at the falling edge and queues the value
// the requirements predict for after the next rising edge; the monitor compares 1 ns after that edge.
module freq_sweep_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sweep_en;
    logic        sweep_dir;
    logic [31:0] lo_word;
    logic [31:0] hi_word;
    logic [39:0] rise_ctl;
    logic [39:0] fall_ctl;
    logic [31:0] ftw_out;

    int unsigned total = 0;
    int unsigned bad   = 0;
    bit          done  = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    // reference state
    logic [31:0] m_cur = '0;
    logic [7:0]  m_cnt = '0;
    bit          m_enq = 1'b0;
    bit          m_dirq = 1'b0;

    always #2.5 clk = ~clk;

    freq_sweep_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sweep_en  (sweep_en),
        .sweep_dir (sweep_dir),
        .lo_word   (lo_word),
        .hi_word   (hi_word),
        .rise_ctl  (rise_ctl),
        .fall_ctl  (fall_ctl),
        .ftw_out   (ftw_out)
    );

    // predict the next output from the inputs now applied
    task automatic predict();
        logic [32:0] wide;
        logic [7:0]  rate;
        bit          load;
        bit          fire;
        string       tag;
        rate = sweep_dir ? rise_ctl[7:0] : fall_ctl[7:0];
        if (!rst_n) begin
            m_cur = '0; m_cnt = '0; m_enq = 1'b0; m_dirq = 1'b0; tag = "R1";
        end else if (!sweep_en) begin
            m_cur = lo_word; m_cnt = rate; m_enq = 1'b0; m_dirq = sweep_dir; tag = "R2";
        end else begin
            load = !m_enq || (sweep_dir != m_dirq);
            fire = !load && (m_cnt == 8'd0);
            if (sweep_dir != m_dirq && m_enq) tag = "R8";
            else if (!m_enq) tag = "R9";
            else tag = "R5";
            if (fire) begin
                if (sweep_dir) begin
                    wide = {1'b0, m_cur} + {1'b0, rise_ctl[39:8]};
                    if (wide[32] || wide[31:0] > hi_word) begin m_cur = hi_word; tag = "R6"; end
                    else begin m_cur = wide[31:0]; tag = "R3"; end
                end else begin
                    wide = {1'b0, m_cur} - {1'b0, fall_ctl[39:8]};
                    if (wide[32] || wide[31:0] < lo_word) begin m_cur = lo_word; tag = "R7"; end
                    else begin m_cur = wide[31:0]; tag = "R4"; end
                end
            end
            if (load || m_cnt == 8'd0) m_cnt = rate;
            else m_cnt = m_cnt - 8'd1;
            m_enq = 1'b1;
            m_dirq = sweep_dir;
        end
        exp_q.push_back(m_cur);
        tag_q.push_back(tag);
    endtask

    // driver: hold the given inputs for n edges, queueing one expectation per edge
    task automatic drive(input bit rst_v, input bit en_v, input bit dir_v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst_n = rst_v; sweep_en = en_v; sweep_dir = dir_v;
            predict();
        end
    endtask

    task automatic setup(input logic [31:0] lo, input logic [31:0] hi,
                         input logic [31:0] du, input logic [7:0] ru,
                         input logic [31:0] dd, input logic [7:0] rd);
        @(negedge clk);
        lo_word = lo; hi_word = hi;
        rise_ctl = {du, ru}; fall_ctl = {dd, rd};
        sweep_en = 1'b0;
        predict();
        drive(1'b1, 1'b0, sweep_dir, 2);
    endtask

    // monitor: compare each produced value with the queued expectation
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (ftw_out !== e) begin
                bad++;
                $display("FAIL %s: ftw_out=%h expected=%h at %0t", t, ftw_out, e, $time);
            end
        end
    end

    initial begin
        rst_n = 1'b0; sweep_en = 1'b0; sweep_dir = 1'b0;
        lo_word = 32'd1000; hi_word = 32'd2000;
        rise_ctl = {32'd100, 8'd3}; fall_ctl = {32'd250, 8'd1};
        // R1: reset state
        drive(1'b0, 1'b1, 1'b1, 3);
        // R2: parked at the lower word
        drive(1'b1, 1'b0, 1'b1, 3);
        // R3, R5, R6, R9: rise at rate 3 until the upper clamp
        drive(1'b1, 1'b1, 1'b1, 50);
        // R4, R7, R8: fall at rate 1 down to the lower clamp
        drive(1'b1, 1'b1, 1'b0, 20);
        // R8: rapid direction toggles
        for (int k = 0; k < 12; k++) drive(1'b1, 1'b1, k[0], 1 + (k % 4));
        drive(1'b1, 1'b1, 1'b1, 9);
        // R6: carry past bit 31 clamps at the upper word
        setup(32'hFFFF_0000, 32'hFFFF_FFF0, 32'h8000_0000, 8'd0, 32'h0000_4000, 8'd2);
        drive(1'b1, 1'b1, 1'b1, 6);
        // R7: borrow below zero clamps at the lower word
        drive(1'b1, 1'b1, 1'b0, 30);
        setup(32'h0000_0010, 32'h0000_1000, 32'h0000_0300, 8'd0, 32'hF000_0000, 8'd0);
        drive(1'b1, 1'b1, 1'b1, 8);
        drive(1'b1, 1'b1, 1'b0, 4);
        // R2: a change of lower word while disabled is followed
        setup(32'h0000_0500, 32'h0000_9000, 32'h0000_0011, 8'd7, 32'h0000_0022, 8'd5);
        // R9: re-enable after a pause
        drive(1'b1, 1'b1, 1'b1, 30);
        drive(1'b1, 1'b0, 1'b1, 2);
        drive(1'b1, 1'b1, 1'b0, 3);
        drive(1'b1, 1'b1, 1'b1, 25);
        // R1: reset in mid sweep
        drive(1'b0, 1'b1, 1'b1, 2);
        drive(1'b1, 1'b1, 1'b1, 10);
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // watchdog
    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: ran out of time, actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule